// File: doc/BRIEF.md
# Load-Color Speculative Squash Tracker

This block sits next to an issue window that lets instructions issue while a load's hit or miss is still unknown. Each speculatively issued load that is dispatched into the window takes a free color from a small pool, and each color is one bit of a dependence vector. A dispatched instruction inherits the OR of the vectors of the window entries that produce its operands. A load also adds its own color. Because of this inheritance, the vector of every entry names all outstanding loads that it depends on, directly or through any number of intermediate producers.

When the memory side reports a miss for a color, every valid entry whose vector holds that bit is squashed in the same cycle. Squashed entries lose their issued flag, stay in the window and may issue again later. The color stays allocated, because the replayed load will report again. When the memory side reports a hit, the bit is cleared from every vector and the color goes back to the pool. An entry may leave the window only after it has issued and its vector is empty. A load cannot be dispatched while all colors are in use.

Top module: `spec_squash_tracker`

## Requirements
- R1: After reset no entry is valid or issued, no color is busy, and `disp_ready_o` is high.
- R2: A load dispatch takes the lowest-numbered free color. `disp_color_o` shows that index in the dispatch cycle. From the next cycle that color is busy and bit `c` of the entry's vector (`ent_colors_o[e*N_COL+c]`) is set.
- R3: A dispatched entry's vector is the OR of the vectors of its enabled source entries. A load also sets its own color bit.
- R4: A miss on a busy color raises `squash_o[e]` in the same cycle for every valid entry `e` whose vector holds that bit, including indirect dependents. From the next cycle those entries are not issued, and entries outside the mask keep their issued flag.
- R5: A miss leaves its color busy and leaves the bit in every vector.
- R6: A hit on a busy color clears that bit in every vector and frees the color from the next cycle on. A dispatch in the same cycle inherits its parents' vectors without that bit.
- R7: While every color is busy, a load dispatch sees `disp_ready_o` low and the entry is not written.
- R8: When a hit and a miss name the same color in one cycle, only the miss takes effect. The color stays busy and the bit remains in every vector.
- R9: `leave_ok_o[e]` is high only for a valid, issued entry with an empty vector. A release request for any other entry is ignored.
- R10: A squash overrides an issue request for the same entry in the same cycle.
- R11: A color that is not busy appears in no entry's vector. A freed color can be given again to a later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_entry_i | input | ENT_W | Window entry to write |
| disp_is_load_i | input | 1 | Dispatched instruction is a load |
| src0_valid_i | input | 1 | First operand comes from a window entry |
| src0_entry_i | input | ENT_W | Producer entry of first operand |
| src1_valid_i | input | 1 | Second operand comes from a window entry |
| src1_entry_i | input | ENT_W | Producer entry of second operand |
| disp_ready_o | output | 1 | Dispatch can be accepted |
| disp_color_o | output | COL_W | Color a load dispatched now would take |
| issue_valid_i | input | 1 | Issue request |
| issue_entry_i | input | ENT_W | Entry being issued |
| rel_valid_i | input | 1 | Release request |
| rel_entry_i | input | ENT_W | Entry asking to leave |
| miss_valid_i | input | 1 | Miss report |
| miss_color_i | input | COL_W | Color of missing load |
| hit_valid_i | input | 1 | Hit report |
| hit_color_i | input | COL_W | Color of hitting load |
| color_busy_o | output | N_COL | Allocated colors |
| ent_valid_o | output | N_ENT | Occupied entries |
| ent_issued_o | output | N_ENT | Entries currently issued |
| ent_colors_o | output | N_ENT*N_COL | Dependence vectors, entry e at bits e*N_COL +: N_COL |
| squash_o | output | N_ENT | Entries squashed this cycle |
| leave_ok_o | output | N_ENT | Entries allowed to leave |

## Verification
The hardest case to reach is a squash that must catch a grandchild. This entry holds the color only through an intermediate non-load, and its vector also carries other colors that must survive. The stimulus builds a three-generation chain that merges two loads, issues every entry, and then misses on the oldest color. In the same cycle it raises an issue request and a hit on that color to check R8 and R10. After that it fills the pool to force a stall, resolves a hit together with a dependent dispatch, and then reuses the freed color.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
  localparam int unsigned SQT_ENTRIES = 8;
  localparam int unsigned SQT_COLORS  = 4;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_FILL = 2'd1,
    ACT_DROP = 2'd2
  } ent_act_e;
endpackage

// File: rtl/sqt_color_pool.sv
module sqt_color_pool #(
  parameter int unsigned N_COL = 4,
  localparam int unsigned COL_W = (N_COL > 1) ? $clog2(N_COL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [N_COL-1:0] release_i,
  output logic [N_COL-1:0] busy_o,
  output logic             avail_o,
  output logic [COL_W-1:0] pick_idx_o,
  output logic [N_COL-1:0] pick_oh_o
);
  logic [N_COL-1:0] busy_q;

  // lowest free color wins
  always_comb begin
    pick_idx_o = '0;
    pick_oh_o  = '0;
    for (int c = N_COL - 1; c >= 0; c--) begin
      if (!busy_q[c]) begin
        pick_idx_o = COL_W'(c);
        pick_oh_o  = N_COL'(1) << c;
      end
    end
  end

  assign avail_o = ~&busy_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~release_i) | (take_i ? pick_oh_o : '0);
  end
endmodule

// File: rtl/sqt_inherit.sv
module sqt_inherit #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned N_COL = 4,
  localparam int unsigned ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0][N_COL-1:0] vecs_i,
  input  logic                        s0_valid_i,
  input  logic [ENT_W-1:0]            s0_idx_i,
  input  logic                        s1_valid_i,
  input  logic [ENT_W-1:0]            s1_idx_i,
  input  logic [N_COL-1:0]            hit_mask_i,
  input  logic                        own_i,
  input  logic [N_COL-1:0]            own_oh_i,
  output logic [N_COL-1:0]            vec_o
);
  logic [N_COL-1:0] p0, p1;

  assign p0 = s0_valid_i ? vecs_i[s0_idx_i] : '0;
  assign p1 = s1_valid_i ? vecs_i[s1_idx_i] : '0;
  // a color retiring this cycle must not be copied into the child
  assign vec_o = ((p0 | p1) & ~hit_mask_i) | (own_i ? own_oh_i : '0);
endmodule

// File: rtl/sqt_entry.sv
module sqt_entry
  import sqt_pkg::*;
#(
  parameter int unsigned N_COL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [N_COL-1:0] fill_vec_i,
  input  logic             issue_i,
  input  logic             rel_i,
  input  logic [N_COL-1:0] miss_mask_i,
  input  logic [N_COL-1:0] hit_mask_i,
  output logic             valid_o,
  output logic             issued_o,
  output logic [N_COL-1:0] vec_o,
  output logic             squash_o,
  output logic             leave_ok_o
);
  logic             valid_q, issued_q;
  logic [N_COL-1:0] vec_q;
  ent_act_e         act;

  assign squash_o   = valid_q & (|(vec_q & miss_mask_i));
  assign leave_ok_o = valid_q & issued_q & ~(|vec_q);

  always_comb begin
    if (fill_i)                  act = ACT_FILL;
    else if (rel_i & leave_ok_o) act = ACT_DROP;
    else                         act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      unique case (act)
        ACT_FILL: begin
          valid_q  <= 1'b1;
          issued_q <= 1'b0;
          vec_q    <= fill_vec_i;
        end
        ACT_DROP: begin
          valid_q  <= 1'b0;
          issued_q <= 1'b0;
          vec_q    <= '0;
        end
        default: begin
          vec_q <= vec_q & ~hit_mask_i;
          if (squash_o)               issued_q <= 1'b0;
          else if (issue_i & valid_q) issued_q <= 1'b1;
        end
      endcase
    end
  end

  assign valid_o  = valid_q;
  assign issued_o = issued_q;
  assign vec_o    = vec_q;
endmodule

// File: rtl/spec_squash_tracker.sv
module spec_squash_tracker #(
  parameter int unsigned N_ENT = sqt_pkg::SQT_ENTRIES,
  parameter int unsigned N_COL = sqt_pkg::SQT_COLORS,
  localparam int unsigned ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int unsigned COL_W = (N_COL > 1) ? $clog2(N_COL) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   disp_valid_i,
  input  logic [ENT_W-1:0]       disp_entry_i,
  input  logic                   disp_is_load_i,
  input  logic                   src0_valid_i,
  input  logic [ENT_W-1:0]       src0_entry_i,
  input  logic                   src1_valid_i,
  input  logic [ENT_W-1:0]       src1_entry_i,
  output logic                   disp_ready_o,
  output logic [COL_W-1:0]       disp_color_o,
  input  logic                   issue_valid_i,
  input  logic [ENT_W-1:0]       issue_entry_i,
  input  logic                   rel_valid_i,
  input  logic [ENT_W-1:0]       rel_entry_i,
  input  logic                   miss_valid_i,
  input  logic [COL_W-1:0]       miss_color_i,
  input  logic                   hit_valid_i,
  input  logic [COL_W-1:0]       hit_color_i,
  output logic [N_COL-1:0]       color_busy_o,
  output logic [N_ENT-1:0]       ent_valid_o,
  output logic [N_ENT-1:0]       ent_issued_o,
  output logic [N_ENT*N_COL-1:0] ent_colors_o,
  output logic [N_ENT-1:0]       squash_o,
  output logic [N_ENT-1:0]       leave_ok_o
);
  logic [N_COL-1:0]            busy, pick_oh, miss_mask, hit_mask, child_vec;
  logic [N_ENT-1:0][N_COL-1:0] vecs;
  logic                        avail, disp_fire, take;

  // reports on free colors are dropped; a miss shadows a hit on the same color
  assign miss_mask = miss_valid_i ? ((N_COL'(1) << miss_color_i) & busy) : '0;
  assign hit_mask  = hit_valid_i  ? ((N_COL'(1) << hit_color_i) & busy & ~miss_mask) : '0;

  assign disp_ready_o = ~disp_is_load_i | avail;
  assign disp_fire    = disp_valid_i & disp_ready_o;
  assign take         = disp_fire & disp_is_load_i;

  sqt_color_pool #(.N_COL(N_COL)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .release_i  (hit_mask),
    .busy_o     (busy),
    .avail_o    (avail),
    .pick_idx_o (disp_color_o),
    .pick_oh_o  (pick_oh)
  );

  sqt_inherit #(.N_ENT(N_ENT), .N_COL(N_COL)) u_inherit (
    .vecs_i     (vecs),
    .s0_valid_i (src0_valid_i),
    .s0_idx_i   (src0_entry_i),
    .s1_valid_i (src1_valid_i),
    .s1_idx_i   (src1_entry_i),
    .hit_mask_i (hit_mask),
    .own_i      (disp_is_load_i),
    .own_oh_i   (pick_oh),
    .vec_o      (child_vec)
  );

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic fill, iss, rel;
    assign fill = disp_fire     & (disp_entry_i  == ENT_W'(e));
    assign iss  = issue_valid_i & (issue_entry_i == ENT_W'(e));
    assign rel  = rel_valid_i   & (rel_entry_i   == ENT_W'(e));

    sqt_entry #(.N_COL(N_COL)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_i      (fill),
      .fill_vec_i  (child_vec),
      .issue_i     (iss),
      .rel_i       (rel),
      .miss_mask_i (miss_mask),
      .hit_mask_i  (hit_mask),
      .valid_o     (ent_valid_o[e]),
      .issued_o    (ent_issued_o[e]),
      .vec_o       (vecs[e]),
      .squash_o    (squash_o[e]),
      .leave_ok_o  (leave_ok_o[e])
    );
    assign ent_colors_o[e*N_COL +: N_COL] = vecs[e];
  end

  assign color_busy_o = busy;
endmodule

// File: rtl/sqt_checker.sv
module sqt_checker #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned N_COL = 4,
  localparam int unsigned COL_W = (N_COL > 1) ? $clog2(N_COL) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   disp_valid_i,
  input logic                   disp_is_load_i,
  input logic                   disp_ready_o,
  input logic                   miss_valid_i,
  input logic [COL_W-1:0]       miss_color_i,
  input logic                   hit_valid_i,
  input logic [COL_W-1:0]       hit_color_i,
  input logic [N_COL-1:0]       color_busy_o,
  input logic [N_ENT-1:0]       ent_valid_o,
  input logic [N_ENT-1:0]       ent_issued_o,
  input logic [N_ENT*N_COL-1:0] ent_colors_o,
  input logic [N_ENT-1:0]       squash_o,
  input logic [N_ENT-1:0]       leave_ok_o
);
  logic [N_COL-1:0] held;
  always_comb begin
    held = '0;
    for (int e = 0; e < N_ENT; e++) held |= ent_colors_o[e*N_COL +: N_COL];
  end

  assert_free_color_unheld_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held & ~color_busy_o) == '0);

  assert_stall_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_is_load_i && (&color_busy_o)) |-> !disp_ready_o);

  assert_squash_unissues_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o != '0) |=> ((ent_issued_o & $past(squash_o)) == '0));

  assert_squash_only_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o & ~ent_valid_o) == '0);

  assert_miss_keeps_color_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && color_busy_o[miss_color_i]) |=> color_busy_o[$past(miss_color_i)]);

  assert_hit_frees_color_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && color_busy_o[hit_color_i] && !(miss_valid_i && miss_color_i == hit_color_i))
    |=> !color_busy_o[$past(hit_color_i)]);

  assert_miss_beats_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && miss_valid_i && hit_color_i == miss_color_i && color_busy_o[hit_color_i])
    |=> color_busy_o[$past(hit_color_i)]);

  assert_leave_needs_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leave_ok_o & ~(ent_valid_o & ent_issued_o)) == '0);
endmodule

bind spec_squash_tracker sqt_checker #(.N_ENT(N_ENT), .N_COL(N_COL)) u_sqt_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .disp_valid_i   (disp_valid_i),
  .disp_is_load_i (disp_is_load_i),
  .disp_ready_o   (disp_ready_o),
  .miss_valid_i   (miss_valid_i),
  .miss_color_i   (miss_color_i),
  .hit_valid_i    (hit_valid_i),
  .hit_color_i    (hit_color_i),
  .color_busy_o   (color_busy_o),
  .ent_valid_o    (ent_valid_o),
  .ent_issued_o   (ent_issued_o),
  .ent_colors_o   (ent_colors_o),
  .squash_o       (squash_o),
  .leave_ok_o     (leave_ok_o)
);

// File: tb/spec_squash_tracker_bench.sv
module spec_squash_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic       disp_valid, disp_load, s0v, s1v, iss_v, rel_v, mv, hv;
  logic [2:0] disp_entry, s0, s1, iss_e, rel_e;
  logic [1:0] mc, hc;
  logic       disp_ready;
  logic [1:0] disp_color;
  logic [NC-1:0]    busy;
  logic [NE-1:0]    valid, issued, squash, leave_ok;
  logic [NE*NC-1:0] colors;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_squash_tracker #(.N_ENT(NE), .N_COL(NC)) u_spec_squash_tracker (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_entry_i(disp_entry), .disp_is_load_i(disp_load),
    .src0_valid_i(s0v), .src0_entry_i(s0), .src1_valid_i(s1v), .src1_entry_i(s1),
    .disp_ready_o(disp_ready), .disp_color_o(disp_color),
    .issue_valid_i(iss_v), .issue_entry_i(iss_e),
    .rel_valid_i(rel_v), .rel_entry_i(rel_e),
    .miss_valid_i(mv), .miss_color_i(mc), .hit_valid_i(hv), .hit_color_i(hc),
    .color_busy_o(busy), .ent_valid_o(valid), .ent_issued_o(issued),
    .ent_colors_o(colors), .squash_o(squash), .leave_ok_o(leave_ok)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } exp_t;
  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;

  // sel: 0 valid, 1 issued, 2 busy, 3 squash, 4 leave_ok, 5 ready, 6 color, 10+e vector of e
  function automatic logic [31:0] probe(int sel);
    case (sel)
      0: return 32'(valid);
      1: return 32'(issued);
      2: return 32'(busy);
      3: return 32'(squash);
      4: return 32'(leave_ok);
      5: return 32'(disp_ready);
      6: return 32'(disp_color);
      default: return 32'(colors[(sel-10)*NC +: NC]);
    endcase
  endfunction

  task automatic expect_item(string req, int sel, logic [31:0] exp);
    exp_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    exp_q.push_back(it);
  endtask

  task automatic monitor();
    while (exp_q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = probe(it.sel);
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  endtask

  task automatic clr_in();
    disp_valid = 0; disp_load = 0; s0v = 0; s1v = 0; iss_v = 0; rel_v = 0; mv = 0; hv = 0;
    disp_entry = 0; s0 = 0; s1 = 0; iss_e = 0; rel_e = 0; mc = 0; hc = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr_in();
  endtask

  task automatic disp(int e, bit ld, bit v0, int p0, bit v1, int p1);
    disp_valid = 1; disp_entry = 3'(e); disp_load = ld;
    s0v = v0; s0 = 3'(p0); s1v = v1; s1 = 3'(p1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    clr_in();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    expect_item("R1", 0, 0); expect_item("R1", 1, 0);
    expect_item("R1", 2, 0); expect_item("R1", 5, 1);
    monitor();

    // R2 load into entry 0 takes color 0
    disp(0, 1, 0, 0, 0, 0); #1;
    expect_item("R2", 6, 0); monitor();
    tick();
    expect_item("R2", 10, 4'b0001); expect_item("R2", 2, 4'b0001); monitor();

    // R3 child of entry 0
    disp(1, 0, 1, 0, 0, 0); tick();
    expect_item("R3", 11, 4'b0001); monitor();

    // R3 load depending on entry 1 gets color 1 plus inherited color 0
    disp(2, 1, 1, 1, 0, 0); #1;
    expect_item("R2", 6, 1); monitor();
    tick();
    expect_item("R3", 12, 4'b0011); monitor();

    disp(3, 1, 0, 0, 0, 0); tick();
    expect_item("R2", 13, 4'b0100); monitor();

    // R3 merge of two producers
    disp(4, 0, 1, 2, 1, 3); tick();
    expect_item("R3", 14, 4'b0111); monitor();
    disp(5, 0, 1, 3, 0, 0); tick();
    expect_item("R3", 15, 4'b0100); monitor();

    for (int e = 0; e < 6; e++) begin
      iss_v = 1; iss_e = 3'(e); tick();
    end
    expect_item("R4", 1, 8'h3F); monitor();

    // R4 miss on color 0: entries 0,1,2 and grandchild 4
    mv = 1; mc = 0; #1;
    expect_item("R4", 3, 8'h17); monitor();
    tick();
    expect_item("R4", 1, 8'h28); expect_item("R5", 2, 4'b0111);
    expect_item("R5", 11, 4'b0001); monitor();

    // R8 and R10: miss with hit on same color and an issue to a squashed entry
    mv = 1; mc = 0; hv = 1; hc = 0; iss_v = 1; iss_e = 0; #1;
    expect_item("R4", 3, 8'h17); monitor();
    tick();
    expect_item("R10", 1, 8'h28); expect_item("R8", 2, 4'b0111);
    expect_item("R8", 11, 4'b0001); expect_item("R8", 14, 4'b0111); monitor();

    // R7 fill the pool, then a load must stall
    disp(6, 1, 0, 0, 0, 0); #1;
    expect_item("R2", 6, 3); monitor();
    tick();
    expect_item("R2", 16, 4'b1000); expect_item("R7", 2, 4'b1111); monitor();
    disp(7, 1, 0, 0, 0, 0); #1;
    expect_item("R7", 5, 0); monitor();
    tick();
    expect_item("R7", 0, 8'h7F); expect_item("R7", 2, 4'b1111); monitor();

    // R6 hit on color 2 with a dependent dispatch in the same cycle
    hv = 1; hc = 2; disp(7, 0, 1, 4, 0, 0); tick();
    expect_item("R6", 17, 4'b0011); expect_item("R6", 14, 4'b0011);
    expect_item("R6", 13, 4'b0000); expect_item("R6", 15, 4'b0000);
    expect_item("R6", 2, 4'b1011); expect_item("R6", 0, 8'hFF); monitor();

    // R9 release rules
    expect_item("R9", 4, 8'h28); monitor();
    rel_v = 1; rel_e = 1; tick();
    expect_item("R9", 0, 8'hFF); monitor();
    rel_v = 1; rel_e = 5; tick();
    expect_item("R9", 0, 8'hDF); expect_item("R9", 1, 8'h08); monitor();

    // R11 freed color 2 is handed out again
    disp(5, 1, 0, 0, 0, 0); #1;
    expect_item("R11", 6, 2); expect_item("R11", 5, 1); monitor();
    tick();
    expect_item("R11", 15, 4'b0100); expect_item("R11", 2, 4'b1111);
    expect_item("R11", 1, 8'h08); monitor();

    // R6 hit on color 0 strips bit 0 everywhere
    hv = 1; hc = 0; tick();
    expect_item("R6", 12, 4'b0010); expect_item("R6", 10, 4'b0000);
    expect_item("R6", 17, 4'b0010); expect_item("R6", 2, 4'b1110); monitor();

    report();
  end
endmodule